// File: doc/BRIEF.md
# Dual PS/2 Port Register Front End

This block gives a processor a register view of two PS/2 ports, a keyboard port and a mouse port. Each port has its own window in a small address space and the same set of registers: identity, receive data, control, status, a reset location and transmit data. The device side of each port is a byte interface. Received bytes arrive on a valid/ready stream with a queue-not-empty flag. Transmitted bytes leave as a one-cycle strobe with data. The serial line transceiver and the keyboard and mouse protocol engines sit outside this block.

Each port has a local loopback mode. In this mode a transmitted byte goes into a one-byte local buffer instead of to the device, and it raises that port's interrupt and a receive-full flag. A diagnostic mode makes the two line-shadow status bits follow the direction bits in the control register. Each port's interrupt comes from its device-side interrupt level or from a pending loopback byte. The two port interrupts are ORed into one interrupt output, and each status register reports that combined interrupt too.

Top module: `ps2_dual_regif`

## Requirements
- R1: Address bit 8 selects the port (0 keyboard, 1 mouse), address bits [3:2] select the register (0 identity/reset, 1 data, 2 control, 3 status), and address bits [7:4] and [1:0] are ignored.
- R2: A read of register 0 returns 0 on the keyboard port and 1 on the mouse port.
- R3: A write to register 2 stores all 8 bits, a read of register 2 returns them unchanged, and reset leaves the control value at 0. Control bit 1 is loopback, bit 5 diagnostic, bit 6 data direction and bit 7 clock direction.
- R4: Status bit 6 (data shadow) reads 0 only when control bit 5 is 1 and control bit 6 is 0, and reads 1 otherwise. Status bit 7 (clock shadow) reads 0 only when control bit 5 is 1 and control bit 7 is 0, and reads 1 otherwise.
- R5: Status bits 1, 2, 3 and 5 always read 0.
- R6: In loopback mode, a write to register 1 stores the byte locally, sets status bit 0 and the port interrupt, and produces no transmit strobe.
- R7: In loopback mode, a read of register 1 returns the stored byte, clears status bit 0 and the loopback interrupt, and does not assert receive ready.
- R8: Outside loopback mode, status bit 0 equals the port's queue-not-empty input. A read of register 1 asserts that port's receive ready for the read cycle when receive valid is high and returns the received byte. When receive valid is low it returns 0 and does not assert ready.
- R9: Outside loopback mode, a write to register 1 drives that port's transmit strobe high for exactly one cycle after the write, with the written byte on its transmit data.
- R10: The interrupt output and status bit 4 of both ports equal the OR of the two port interrupts. Each port interrupt is its device interrupt input ORed with its loopback interrupt.
- R11: A write to register 0 changes no register, flag or output.
- R12: The read data valid output is high exactly in the cycle after a read strobe, and read data holds the addressed register's value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address; bit 8 port, bits [3:2] register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| rx_valid | input | 2 | Per-port received byte valid |
| rx_data | input | 16 | Per-port received byte (port 1 in upper byte) |
| rx_ready | output | 2 | Per-port pop of the received byte |
| rx_nonempty | input | 2 | Per-port device queue not empty |
| dev_irq | input | 2 | Per-port device interrupt level |
| tx_strobe | output | 2 | Per-port transmit strobe |
| tx_data | output | 16 | Per-port transmit byte |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps all 256 control values on both ports, with the unused address bits scrambled. A design that decoded an extra address bit would land on the wrong register, and one with an inverted or swapped shadow rule would miss the values where only one direction bit is set. The loopback round trip checks that no transmit strobe leaks to the device, that a read releases both the receive flag and the interrupt, and that no device byte is popped on the way. Reset-location writes, an empty-queue read and a mouse-only device interrupt are also checked. A design that let any of these alter state, pop a byte, or keep the interrupt local to one port would fail the bench.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;
  typedef enum logic [1:0] {
    OFF_ID   = 2'd0,
    OFF_DATA = 2'd1,
    OFF_CTRL = 2'd2,
    OFF_STAT = 2'd3
  } ps2r_off_e;

  localparam int CB_LOOP = 1;
  localparam int CB_DIAG = 5;
  localparam int CB_DDIR = 6;
  localparam int CB_CDIR = 7;

  localparam int SB_RXNE = 0;
  localparam int SB_IRQ  = 4;
  localparam int SB_DSHD = 6;
  localparam int SB_CSHD = 7;
endpackage

// File: rtl/ps2r_irq_merge.sv
module ps2r_irq_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] irq_in,
  output logic         irq_any
);
  assign irq_any = |irq_in;
endmodule

// File: rtl/ps2r_port.sv
module ps2r_port
  import ps2r_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PORT_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel,
  input  logic          wr_sel,
  input  logic [1:0]    off,
  input  logic [DW-1:0] wdata,
  input  logic          irq_any,
  output logic [DW-1:0] rd_word,
  output logic          irq_port,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_nonempty,
  output logic          rx_ready,
  input  logic          dev_irq,
  output logic          tx_strobe,
  output logic [DW-1:0] tx_data
);
  ps2r_off_e     reg_sel;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] lb_buf_q, lb_buf_d;
  logic          lb_full_q, lb_full_d;
  logic          lb_irq_q, lb_irq_d;
  logic          tx_stb_q, tx_stb_d;
  logic [DW-1:0] tx_data_q, tx_data_d;
  logic          loop_on;
  logic [DW-1:0] stat_word;

  assign reg_sel = ps2r_off_e'(off);
  assign loop_on = ctrl_q[CB_LOOP];

  always_comb begin
    ctrl_d    = ctrl_q;
    lb_buf_d  = lb_buf_q;
    lb_full_d = lb_full_q;
    lb_irq_d  = lb_irq_q;
    tx_stb_d  = 1'b0;
    tx_data_d = tx_data_q;
    if (wr_sel) begin
      case (reg_sel)
        OFF_CTRL: ctrl_d = wdata;
        OFF_DATA: begin
          if (loop_on) begin
            lb_buf_d  = wdata;
            lb_full_d = 1'b1;
            lb_irq_d  = 1'b1;
          end else begin
            tx_stb_d  = 1'b1;
            tx_data_d = wdata;
          end
        end
        default: ;
      endcase
    end
    if (rd_sel && reg_sel == OFF_DATA && loop_on) begin
      lb_full_d = 1'b0;
      lb_irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      lb_buf_q  <= '0;
      lb_full_q <= 1'b0;
      lb_irq_q  <= 1'b0;
      tx_stb_q  <= 1'b0;
      tx_data_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      lb_buf_q  <= lb_buf_d;
      lb_full_q <= lb_full_d;
      lb_irq_q  <= lb_irq_d;
      tx_stb_q  <= tx_stb_d;
      tx_data_q <= tx_data_d;
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[SB_RXNE] = loop_on ? lb_full_q : rx_nonempty;
    stat_word[SB_IRQ]  = irq_any;
    stat_word[SB_DSHD] = !(ctrl_q[CB_DIAG] && !ctrl_q[CB_DDIR]);
    stat_word[SB_CSHD] = !(ctrl_q[CB_DIAG] && !ctrl_q[CB_CDIR]);
  end

  always_comb begin
    case (reg_sel)
      OFF_ID:   rd_word = DW'(PORT_ID);
      OFF_DATA: rd_word = loop_on ? lb_buf_q : (rx_valid ? rx_data : '0);
      OFF_CTRL: rd_word = ctrl_q;
      default:  rd_word = stat_word;
    endcase
  end

  assign rx_ready  = rd_sel && reg_sel == OFF_DATA && !loop_on && rx_valid;
  assign irq_port  = lb_irq_q | dev_irq;
  assign tx_strobe = tx_stb_q;
  assign tx_data   = tx_data_q;
endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif #(
  parameter int DW       = 8,
  parameter int NPORTS   = 2,
  parameter int WIN_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [8:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NPORTS-1:0]    rx_valid,
  input  logic [NPORTS*DW-1:0] rx_data,
  output logic [NPORTS-1:0]    rx_ready,
  input  logic [NPORTS-1:0]    rx_nonempty,
  input  logic [NPORTS-1:0]    dev_irq,
  output logic [NPORTS-1:0]    tx_strobe,
  output logic [NPORTS*DW-1:0] tx_data,
  output logic                 irq
);
  localparam int PSW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [PSW-1:0]    psel;
  logic [1:0]        off;
  logic [DW-1:0]     rd_words [NPORTS];
  logic [NPORTS-1:0] irq_ports;
  logic              irq_any;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              rvalid_q;

  assign psel = bus_addr[WIN_BITS +: PSW];
  assign off  = bus_addr[3:2];

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
    ps2r_port #(.DW(DW), .PORT_ID(gi)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_sel     (bus_rd && psel == PSW'(gi)),
      .wr_sel     (bus_wr && psel == PSW'(gi)),
      .off        (off),
      .wdata      (bus_wdata),
      .irq_any    (irq_any),
      .rd_word    (rd_words[gi]),
      .irq_port   (irq_ports[gi]),
      .rx_valid   (rx_valid[gi]),
      .rx_data    (rx_data[gi*DW +: DW]),
      .rx_nonempty(rx_nonempty[gi]),
      .rx_ready   (rx_ready[gi]),
      .dev_irq    (dev_irq[gi]),
      .tx_strobe  (tx_strobe[gi]),
      .tx_data    (tx_data[gi*DW +: DW])
    );
  end

  ps2r_irq_merge #(.N(NPORTS)) u_irq (
    .irq_in (irq_ports),
    .irq_any(irq_any)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_words[psel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= bus_rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq        = irq_any;
endmodule

// File: rtl/ps2r_checker.sv
module ps2r_checker #(
  parameter int DW     = 8,
  parameter int NPORTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [8:0]           bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic                 bus_rvalid,
  input logic [NPORTS-1:0]    rx_valid,
  input logic [NPORTS-1:0]    rx_ready,
  input logic [NPORTS-1:0]    dev_irq,
  input logic [NPORTS-1:0]    tx_strobe,
  input logic                 irq
);
  a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  a_r12_rvalid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  a_r8_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready[0] |-> (rx_valid[0] && bus_rd && !bus_addr[8] && bus_addr[3:2] == 2'd1));
  a_r8_ready_mouse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready[1] |-> (rx_valid[1] && bus_rd && bus_addr[8] && bus_addr[3:2] == 2'd1));
  a_r9_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr[3:2] != 2'd1 |=> tx_strobe == '0);
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe[0] |=> !tx_strobe[0]);
  a_r10_dev_irq_reaches_out: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq != '0) |-> irq);
  a_r11_reset_write_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd0) |=> $onehot0(tx_strobe) && tx_strobe == '0);
endmodule

bind ps2_dual_regif ps2r_checker #(.DW(DW), .NPORTS(NPORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rvalid(bus_rvalid),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .dev_irq   (dev_irq),
  .tx_strobe (tx_strobe),
  .irq       (irq)
);

// File: tb/ps2_dual_regif_bench.sv
module ps2_dual_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  rx_valid = '0;
  logic [15:0] rx_data = '0;
  logic [1:0]  rx_ready;
  logic [1:0]  rx_nonempty = '0;
  logic [1:0]  dev_irq = '0;
  logic [1:0]  tx_strobe;
  logic [15:0] tx_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int tx_count = 0;
  logic [7:0] rd_val;
  logic       rd_vld;
  logic [1:0] rd_rdy;

  always #10 clk = ~clk;

  ps2_dual_regif u_ps2_dual_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_nonempty(rx_nonempty), .dev_irq(dev_irq), .tx_strobe(tx_strobe),
    .tx_data(tx_data), .irq(irq)
  );

  always @(posedge clk) if (rst_n) tx_count <= tx_count + int'(tx_strobe[0]) + int'(tx_strobe[1]);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 rd_rdy = rx_ready;
    @(negedge clk);
    bus_rd = 1'b0;
    rd_val = bus_rdata;
    rd_vld = bus_rvalid;
  endtask

  function automatic logic [7:0] exp_stat(input logic [7:0] c, input logic rbne, input logic ia);
    logic [7:0] s;
    s = '0;
    s[0] = c[1] ? 1'b0 : rbne;
    s[4] = ia;
    s[6] = !(c[5] && !c[6]);
    s[7] = !(c[5] && !c[7]);
    return s;
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check("R12 reset rvalid", 16'(bus_rvalid), 0);
    check("R10 reset irq", 16'(irq), 0);
    check("R9 reset strobe", 16'(tx_strobe), 0);
    rst_n = 1'b1;
    rd(9'h008);
    check("R3 reset ctrl", 16'(rd_val), 0);
    check("R12 rvalid after read", 16'(rd_vld), 1);
    @(negedge clk);
    check("R12 rvalid drops", 16'(bus_rvalid), 0);

    rd(9'h0F0); check("R2 R1 kbd id", 16'(rd_val), 0);
    rd(9'h1A3); check("R2 R1 mouse id", 16'(rd_val), 1);

    // R3 R4 R5 R1 sweep: every control value, both ports, scrambled ignored bits
    rx_nonempty = 2'b01;
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] c;
        c = 8'(v);
        wr({p[0], c[7:4], 2'b10, c[1:0]}, c);
        rd({p[0], c[3:0], 2'b10, ~c[1:0]});
        check("R3 ctrl readback", 16'(rd_val), 16'(c));
        rd({p[0], ~c[7:4], 2'b11, ~c[1:0]});
        check("R4 R5 status", 16'(rd_val), 16'(exp_stat(c, p == 0, 1'b0)));
      end
      wr({p[0], 8'h08}, 8'h00);
    end
    rx_nonempty = 2'b00;
    check("R6 sweep no tx", 16'(tx_count), 0);

    // R9 normal transmit on keyboard
    wr(9'h004, 8'h5C);
    check("R9 strobe", 16'(tx_strobe), 16'b01);
    check("R9 data", tx_data[7:0], 16'h5C);
    @(negedge clk);
    check("R9 strobe single", 16'(tx_strobe), 0);
    wr(9'h1F4, 8'hC3);
    check("R9 mouse strobe", 16'(tx_strobe), 16'b10);
    check("R9 mouse data", tx_data[15:8], 16'hC3);

    // R8 receive pop
    rx_valid = 2'b01; rx_data = 16'hAA3C; rx_nonempty = 2'b01;
    rd(9'h008); rd(9'h00C);
    check("R8 rbne from queue", 16'(rd_val[0]), 1);
    rd(9'h004);
    check("R8 ready pulse", 16'(rd_rdy), 16'b01);
    check("R8 rx byte", 16'(rd_val), 16'h3C);
    rx_valid = 2'b00; rx_nonempty = 2'b00;
    rd(9'h004);
    check("R8 empty read zero", 16'(rd_val), 0);
    check("R8 empty no ready", 16'(rd_rdy), 0);

    // R6 R7 loopback on mouse
    wr(9'h108, 8'h03);
    tx_count = 0;
    rx_valid = 2'b10; rx_data = 16'h7700;
    wr(9'h104, 8'hA5);
    @(negedge clk);
    check("R6 no strobe", 16'(tx_count), 0);
    check("R6 R10 irq set", 16'(irq), 1);
    rd(9'h10C);
    check("R6 rbne set", 16'(rd_val[0]), 1);
    rd(9'h00C);
    check("R10 kbd sees combined", 16'(rd_val[4]), 1);
    // R11 reset offset writes change nothing
    wr(9'h000, 8'hFF); wr(9'h100, 8'hFF);
    check("R11 no tx", 16'(tx_count), 0);
    check("R11 irq kept", 16'(irq), 1);
    rd(9'h108); check("R11 ctrl kept", 16'(rd_val), 16'h03);
    rd(9'h10C); check("R11 rbne kept", 16'(rd_val[0]), 1);
    rd(9'h104);
    check("R7 loop byte", 16'(rd_val), 16'hA5);
    check("R7 no ready", 16'(rd_rdy), 0);
    check("R7 irq cleared", 16'(irq), 0);
    rd(9'h10C);
    check("R7 rbne cleared", 16'(rd_val), 16'(exp_stat(8'h03, 1'b0, 1'b0)));
    rx_valid = 2'b00;

    // R10 device interrupt on mouse only
    dev_irq = 2'b10;
    @(negedge clk);
    check("R10 irq out", 16'(irq), 1);
    rd(9'h00C);
    check("R10 kbd status irq", 16'(rd_val[4]), 1);
    dev_irq = 2'b00;
    @(negedge clk);
    check("R10 irq low", 16'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule